// File: doc/BRIEF.md
# Chained Dual-Channel Timebase

The block builds one free-running wide timebase from two narrow counter channels. The lower channel counts ticks from a prescaled system clock. From its own count it generates a square waveform. The waveform goes high when the lower count reaches zero and goes low when it reaches half of its range. When chaining is enabled, each rising edge of that waveform advances the upper channel. Software reads the combined value in one access. It can also read it as two halves: a read of the low half captures the high half in a holding register, so the pair it gets is coherent.

A configuration pin selects a wide single-channel mode. In that mode the lower channel alone counts the full double width and the upper channel stays idle. A command write clears every counter, the prescaler and the waveform on the same clock edge. At reset the prescaler select takes the largest divisor that still gives a tick rate at or above a minimum rate. That choice is computed from the clock frequency parameter.

Top module: `chained_timebase`

## Requirements
- R1: After reset, reads of the configuration register (address 1) return the divisor select computed from the parameters, with the run bit and the chain bit both 0. All counts read 0 and `wave_out` is 1.
- R2: In the configuration register, bits [1:0] select the divisor: 0 gives /2, 1 gives /8, 2 gives /32 and 3 gives /128. Bit 2 is run. While run is 1, the lower count advances by one every divisor cycles, counted from the last clear. While run is 0 the lower count holds.
- R3: Outside wide mode, `wave_out` is updated at each clock edge from the lower count it held before that edge. It becomes 1 if the low half was 0, becomes 0 if it was half the channel range, and otherwise holds. In wide mode it becomes 0. A clear sets it to 1.
- R4: In narrow mode with bit 3 (chain) set, the upper count increments by one at the edge after the one where `wave_out` rose. This is two edges after the lower count wraps to zero.
- R5: With the chain bit at 0, the upper count never changes except by a clear.
- R6: A read of address 2 returns {upper count, low half of the lower count} in narrow mode. In wide mode it returns the full-width lower count. In wide mode the upper count holds.
- R7: A read of address 3 returns the low half of the combined value and captures its high half. A read of address 4 returns the captured half, which later counting does not alter.
- R8: Writing 1 in bit 0 of address 0 clears both counts and the prescaler at that edge. Counting resumes from 0, and the clear causes no upper increment.
- R9: Read data appears on `rdata` one cycle after `rd_en` and holds until the next read. Address 0 and addresses 5 to 7 read 0. The configuration register reads back as written in bits [3:0].
- R10: If the divisor is reduced while the prescaler count already exceeds the new limit, a tick occurs on the next edge rather than after a prescaler wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | 1 selects wide single-channel counting |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register address |
| wdata | input | 2*CH_W | Write data |
| rdata | output | 2*CH_W | Read data, registered |
| wave_out | output | 1 | Lower channel waveform |

## Verification
Read data is due one cycle after the strobe edge and shows the counts as they stood before that edge. A clear or configuration write takes effect at the same edge. The waveform follows the lower count by one edge, and the upper count follows the waveform's rise by one more. The bench keeps a cycle model that is advanced at each rising edge by these stated rules, compares outputs at the falling edge, and adds directed reads whose expected values are computed from those edge counts.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int PRE_W = 7;

    typedef enum logic [1:0] {
        DIV_BY2   = 2'd0,
        DIV_BY8   = 2'd1,
        DIV_BY32  = 2'd2,
        DIV_BY128 = 2'd3
    } div_sel_e;

    typedef enum logic [2:0] {
        REG_CMD   = 3'd0,
        REG_CFG   = 3'd1,
        REG_COUNT = 3'd2,
        REG_LOW   = 3'd3,
        REG_HIGH  = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic     chain;
        logic     run;
        div_sel_e sel;
    } cfg_t;

    localparam int CFG_W    = $bits(cfg_t);
    localparam int SYNC_BIT = 0;

    // terminal prescaler value for a given select
    function automatic logic [PRE_W-1:0] div_minus1(input div_sel_e s);
        logic [7:0] d;
        d = 8'd2 << {s, 1'b0};
        return PRE_W'(d - 8'd1);
    endfunction

    // largest divisor whose tick rate still reaches min_hz
    function automatic div_sel_e pick_div(input longint unsigned clk_hz,
                                          input longint unsigned min_hz);
        for (int i = 3; i >= 0; i--) begin
            if ((clk_hz / (64'd2 << (2 * i))) >= min_hz)
                return div_sel_e'(2'(i));
        end
        return DIV_BY2;
    endfunction

endpackage

// File: rtl/tbase_prescaler.sv
module tbase_prescaler
    import tbase_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     sync_clr,
    input  logic     run,
    input  div_sel_e sel,
    output logic     tick
);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    assign limit = div_minus1(sel);
    assign tick  = run && (pre_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || sync_clr)
            pre_q <= '0;
        else if (run)
            pre_q <= tick ? '0 : pre_q + 1'b1;
    end

    // R2
    tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R10
    pre_reset_chk: assert property (@(posedge clk) disable iff (rst)
        tick |=> (pre_q == '0));

endmodule

// File: rtl/tbase_lo_chan.sv
module tbase_lo_chan #(
    parameter int CH_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sync_clr,
    input  logic              tick,
    input  logic              wide,
    output logic [2*CH_W-1:0] cnt,
    output logic              wave
);

    localparam int CNT_W = 2 * CH_W;
    localparam logic [CH_W-1:0] HALF = {1'b1, {(CH_W-1){1'b0}}};

    logic [CH_W-1:0]  low_part;
    logic [CNT_W-1:0] cnt_inc;

    assign low_part = cnt[CH_W-1:0];

    always_comb begin
        if (wide)
            cnt_inc = cnt + 1'b1;
        else
            cnt_inc = {{CH_W{1'b0}}, low_part + 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst || sync_clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt_inc;
    end

    // compare-driven waveform: set at zero, cleared at half range
    always_ff @(posedge clk) begin
        if (rst || sync_clr)
            wave <= 1'b1;
        else if (wide)
            wave <= 1'b0;
        else if (low_part == '0)
            wave <= 1'b1;
        else if (low_part == HALF)
            wave <= 1'b0;
    end

    // R2
    lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_clr && !tick) |=> $stable(cnt));

    // R3
    wave_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_clr && low_part == HALF) |=> !wave);

    // R3
    wave_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_clr && !wide && low_part == '0) |=> wave);

endmodule

// File: rtl/tbase_hi_chan.sv
module tbase_hi_chan #(
    parameter int CH_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            sync_clr,
    input  logic            wave,
    input  logic            count_en,
    output logic [CH_W-1:0] cnt
);

    logic wave_d;
    logic rise;

    assign rise = wave && !wave_d;

    always_ff @(posedge clk) begin
        if (rst || sync_clr)
            wave_d <= 1'b1;
        else
            wave_d <= wave;
    end

    always_ff @(posedge clk) begin
        if (rst || sync_clr)
            cnt <= '0;
        else if (rise && count_en)
            cnt <= cnt + 1'b1;
    end

    // R4
    hi_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_clr && rise && count_en) |=> (cnt == CH_W'($past(cnt) + 1'b1)));

    // R5
    hi_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!sync_clr && !(rise && count_en)) |=> $stable(cnt));

endmodule

// File: rtl/chained_timebase.sv
module chained_timebase
    import tbase_pkg::*;
#(
    parameter int              CH_W        = 16,
    parameter longint unsigned CLK_HZ      = 66_000_000,
    parameter longint unsigned MIN_RATE_HZ = 5_000_000,
    parameter int              ADDR_W      = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mode_wide,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [2*CH_W-1:0]   wdata,
    output logic [2*CH_W-1:0]   rdata,
    output logic                wave_out
);

    localparam int       DATA_W  = 2 * CH_W;
    localparam div_sel_e DEF_SEL = pick_div(CLK_HZ, MIN_RATE_HZ);

    localparam logic [ADDR_W-1:0] AD_CMD   = ADDR_W'(REG_CMD);
    localparam logic [ADDR_W-1:0] AD_CFG   = ADDR_W'(REG_CFG);
    localparam logic [ADDR_W-1:0] AD_COUNT = ADDR_W'(REG_COUNT);
    localparam logic [ADDR_W-1:0] AD_LOW   = ADDR_W'(REG_LOW);
    localparam logic [ADDR_W-1:0] AD_HIGH  = ADDR_W'(REG_HIGH);

    cfg_t              cfg_q;
    logic              sync_clr;
    logic              tick;
    logic [DATA_W-1:0] lo_cnt;
    logic [CH_W-1:0]   hi_cnt;
    logic              wave;
    logic [DATA_W-1:0] view;
    logic [CH_W-1:0]   hold_q;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wdata;

    assign unused_wdata = ^wdata[DATA_W-1:CFG_W];

    assign sync_clr = wr_en && (addr == AD_CMD) && wdata[SYNC_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.chain <= 1'b0;
            cfg_q.run   <= 1'b0;
            cfg_q.sel   <= DEF_SEL;
        end else if (wr_en && addr == AD_CFG) begin
            cfg_q <= cfg_t'(wdata[CFG_W-1:0]);
        end
    end

    tbase_prescaler u_pre (
        .clk      (clk),
        .rst      (rst),
        .sync_clr (sync_clr),
        .run      (cfg_q.run),
        .sel      (cfg_q.sel),
        .tick     (tick)
    );

    tbase_lo_chan #(.CH_W(CH_W)) u_lo (
        .clk      (clk),
        .rst      (rst),
        .sync_clr (sync_clr),
        .tick     (tick),
        .wide     (mode_wide),
        .cnt      (lo_cnt),
        .wave     (wave)
    );

    tbase_hi_chan #(.CH_W(CH_W)) u_hi (
        .clk      (clk),
        .rst      (rst),
        .sync_clr (sync_clr),
        .wave     (wave),
        .count_en (cfg_q.chain && !mode_wide),
        .cnt      (hi_cnt)
    );

    assign wave_out = wave;
    assign view     = mode_wide ? lo_cnt : {hi_cnt, lo_cnt[CH_W-1:0]};

    always_comb begin
        rd_mux = '0;
        case (addr)
            AD_CFG:   rd_mux = {{(DATA_W-CFG_W){1'b0}}, cfg_q};
            AD_COUNT: rd_mux = view;
            AD_LOW:   rd_mux = {{CH_W{1'b0}}, view[CH_W-1:0]};
            AD_HIGH:  rd_mux = {{CH_W{1'b0}}, hold_q};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            hold_q <= '0;
        else if (rd_en && addr == AD_LOW)
            hold_q <= view[DATA_W-1:CH_W];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rdata <= '0;
        else if (rd_en)
            rdata <= rd_mux;
    end

    // R8
    sync_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sync_clr |=> (lo_cnt == '0 && hi_cnt == '0 && wave_out));

    // R6
    wide_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_wide && !sync_clr) |=> $stable(hi_cnt));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_en && addr == AD_LOW) |=> $stable(hold_q));

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/chained_timebase_tb.sv
module chained_timebase_tb;

    localparam int CH_W   = 8;
    localparam int DATA_W = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mode_wide = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [2:0]        addr = '0;
    logic [DATA_W-1:0] wdata = '0;
    logic [DATA_W-1:0] rdata;
    logic              wave_out;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    done     = 1'b0;
    string cur_tag  = "";

    always #5 clk = ~clk;

    chained_timebase #(
        .CH_W        (CH_W),
        .CLK_HZ      (200_000_000),
        .MIN_RATE_HZ (5_000_000),
        .ADDR_W      (3)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .mode_wide (mode_wide),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .wave_out  (wave_out)
    );

    // cycle model built from the requirements
    int unsigned       m_pre;
    logic [15:0]       m_lo;
    logic [7:0]        m_hi;
    logic [7:0]        m_hold;
    logic              m_wave, m_wd;
    logic [3:0]        m_cfg;
    logic [15:0]       m_rdata;
    logic              m_rd_pend;
    string             m_tag;

    function automatic string auto_tag(input logic [2:0] a, input logic w);
        case (a)
            3'd2:    return w ? "R6" : "R4";
            3'd3:    return "R7";
            3'd4:    return "R7";
            default: return "R9";
        endcase
    endfunction

    always @(posedge clk) begin : model
        int unsigned d;
        logic        tk, s;
        logic [15:0] view, rv;
        if (rst) begin
            m_pre <= 0; m_lo <= '0; m_hi <= '0; m_hold <= '0;
            m_wave <= 1'b1; m_wd <= 1'b1; m_cfg <= 4'b0010;
            m_rdata <= '0; m_rd_pend <= 1'b0; m_tag <= "";
        end else begin
            s    = wr_en && addr == 3'd0 && wdata[0];
            d    = 2 << (2 * m_cfg[1:0]);
            tk   = m_cfg[2] && (m_pre >= d - 1);
            view = mode_wide ? m_lo : {m_hi, m_lo[7:0]};
            case (addr)
                3'd1:    rv = {12'h0, m_cfg};
                3'd2:    rv = view;
                3'd3:    rv = {8'h0, view[7:0]};
                3'd4:    rv = {8'h0, m_hold};
                default: rv = '0;
            endcase
            m_rd_pend <= rd_en;
            if (rd_en) begin
                m_rdata <= rv;
                m_tag   <= (cur_tag != "") ? cur_tag : auto_tag(addr, mode_wide);
            end
            if (rd_en && addr == 3'd3) m_hold <= view[15:8];
            if (wr_en && addr == 3'd1) m_cfg <= wdata[3:0];
            if (s) begin
                m_pre <= 0; m_lo <= '0; m_hi <= '0; m_wave <= 1'b1; m_wd <= 1'b1;
            end else begin
                if (m_cfg[2]) m_pre <= tk ? 0 : m_pre + 1;
                if (tk) m_lo <= mode_wide ? m_lo + 16'd1 : {8'h0, m_lo[7:0] + 8'd1};
                if (mode_wide)              m_wave <= 1'b0;
                else if (m_lo[7:0] == 8'd0)   m_wave <= 1'b1;
                else if (m_lo[7:0] == 8'd128) m_wave <= 1'b0;
                m_wd <= m_wave;
                if (!mode_wide && m_cfg[3] && m_wave && !m_wd) m_hi <= m_hi + 8'd1;
            end
        end
    end

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check({31'h0, wave_out}, {31'h0, m_wave}, "R3");
            if (m_rd_pend) check({16'h0, rdata}, {16'h0, m_rdata}, m_tag);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic rd(input int a, input string t);
        addr = 3'(a); rd_en = 1'b1; cur_tag = t;
        step();
        rd_en = 1'b0; cur_tag = "";
    endtask

    task automatic wr(input int a, input int v);
        addr = 3'(a); wdata = 16'(v); wr_en = 1'b1;
        step();
        wr_en = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            done = 1'b1;
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) step();
        rst = 1'b0;
        step();

        // R1: reset state
        check({31'h0, wave_out}, 32'd1, "R1");
        rd(1, "R1"); check({16'h0, rdata}, 32'd2, "R1");
        rd(2, "R1"); check({16'h0, rdata}, 32'd0, "R1");

        // R2: /8, count after 78 edges from clear is 9
        wr(1, 'b1101);
        wr(0, 1);
        repeat (78) step();
        rd(2, "R2"); check({16'h0, rdata}, 32'd9, "R2");

        // R8: clear then immediate read
        wr(0, 1);
        rd(2, "R8"); check({16'h0, rdata}, 32'd0, "R8");

        // R4: /2 chained, two wraps, lower at 10
        wr(1, 'b1100);
        wr(0, 1);
        repeat (1044) step();
        rd(2, "R4"); check({16'h0, rdata}, 32'h020A, "R4");

        // R5: chain off, upper stays 0
        wr(1, 'b0100);
        wr(0, 1);
        repeat (1044) step();
        rd(2, "R5"); check({16'h0, rdata}, 32'h000A, "R5");

        // R7: split read coherence
        wr(1, 'b1100);
        wr(0, 1);
        repeat (600) step();
        rd(3, "R7"); check({16'h0, rdata}, 32'd44, "R7");
        repeat (600) step();
        rd(4, "R7"); check({16'h0, rdata}, 32'd1, "R7");

        // R6: wide mode
        mode_wide = 1'b1;
        wr(0, 1);
        repeat (1044) step();
        rd(2, "R6"); check({16'h0, rdata}, 32'h020A, "R6");
        check({31'h0, wave_out}, 32'd0, "R6");
        mode_wide = 1'b0;
        wr(0, 1);

        // R10: shrink divisor mid-count
        wr(1, 'b0111);
        wr(0, 1);
        repeat (100) step();
        wr(1, 'b0100);
        repeat (10) step();
        rd(2, "R10"); check({16'h0, rdata}, 32'd5, "R10");

        // R9: unmapped and readback
        rd(7, "R9"); check({16'h0, rdata}, 32'd0, "R9");
        rd(1, "R9"); check({16'h0, rdata}, 32'd4, "R9");

        // constrained random phase against the model
        for (int i = 0; i < 20000; i++) begin
            int r;
            r = $urandom % 1000;
            wr_en = 1'b0; rd_en = 1'b0;
            if (r < 25) begin
                int sel;
                sel = ($urandom % 4 == 0) ? ($urandom % 4) : 0;
                wr_en = 1'b1; addr = 3'd1;
                wdata = 16'({($urandom % 4 != 0) ? 1'b1 : 1'b0,
                             ($urandom % 8 != 0) ? 1'b1 : 1'b0, 2'(sel)});
            end else if (r < 32) begin
                wr_en = 1'b1; addr = 3'd0; wdata = 16'($urandom);
            end else if (r < 35) begin
                mode_wide = ~mode_wide;
            end else if (r < 700) begin
                rd_en = 1'b1; addr = 3'($urandom % 8);
            end
            step();
        end
        wr_en = 1'b0; rd_en = 1'b0;
        step();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule